// File: doc/BRIEF.md
# Two-Wire Block-Wrapped EEPROM Slave

This block is the serial front end of a 1 KB nonvolatile store. The store is split into eight blocks of 128 bytes, and each block holds eight pages of 16 bytes. The block listens on a two-wire bus, with the clock and data lines sampled through synchronisers. It recognises START and STOP conditions, shifts bytes in and out most-significant bit first, and decodes the device address byte. For a write command it captures the target address and performs a page write. For a read command it streams bytes out of the block that the last write command selected.

A second pair of device codes opens a small configuration space of 32 single-byte locations. This space is reached through the same memory port, with a select flag raised. Access permission for each block comes from an external protection unit on two 8-bit masks, and the block answers ACK or NACK from them. A write-protect pin refuses every data byte but still allows an address to be set.

After a STOP that ends a transaction which wrote data, the block models the internal programming time. For a parameterised number of clock cycles it NACKs every device address. A low level on the power-good input holds the whole interface in reset.

Top module: `tws_eeprom_slave`

## Requirements
- R1: A device byte whose upper five bits are 10101 (hex A8 to AF) selects the main array and is ACKed when the block is idle and permitted. Any byte other than these and hex B8/B9 is NACKed.
- R2: On a write command the memory address is formed as {device bits 2:1, word byte bits 7:0}. Word bit 7 is the low block bit, bits 6:4 give the page and bits 3:0 give the byte in the page.
- R3: Successive data bytes of one write go to consecutive addresses. After byte 15 of a page the address returns to byte 0 of the same page.
- R4: A read command ignores its device bits 2:1 and starts at the address left by the last write command. Each master-acknowledged byte advances the address within the same 128-byte block, so byte 127 is followed by byte 0 of that block.
- R5: Device bytes hex B8 (write) and B9 (read) select the configuration space. A word byte from hex 00 to 1F is ACKed and becomes the configuration address, shown on memAddr with memCfg high. A word byte with any of bits 7:5 set is NACKed.
- R6: The configuration space moves one byte per transaction. A second data byte in one write is NACKed and not stored. After one read byte the slave releases SDA, so any further bytes read as hex FF.
- R7: While wpIn is high, every data byte is NACKed and memWe stays low. The word byte is still ACKed and latched, so a following read starts from it.
- R8: A data byte to a block whose permWr bit is 0 is NACKed and not written. A read device byte is NACKed when the permRd bit of the latched block is 0.
- R9: After a STOP that closes a transaction in which at least one byte was written, every device byte is NACKed for BUSY_CYCLES clock cycles.
- R10: While protN is low, SDA is released, the memory port is idle and the latched addresses return to zero.
- R11: Bits travel most-significant first. memRe is issued one cycle before memRdata is used, and a read and a write never share a cycle on the memory port.
- R12: A repeated START without a STOP begins a new device byte and keeps the address latched by the preceding write command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| protN | input | 1 | Power-good; low holds the interface in reset |
| wpIn | input | 1 | Write-protect pin; high refuses data bytes |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaOutEn | output | 1 | High pulls SDA low (open drain) |
| permRd | input | 8 | Per-block read permission from the protection unit |
| permWr | input | 8 | Per-block write permission from the protection unit |
| memCfg | output | 1 | High when the access targets the configuration space |
| memAddr | output | 10 | Memory or configuration address |
| memWe | output | 1 | Write strobe for one byte |
| memWdata | output | 8 | Write data |
| memRe | output | 1 | Read strobe; data is expected on memRdata one cycle later |
| memRdata | input | 8 | Read data returned by the memory |

## Verification
The assertions assume that permRd, permWr and wpIn hold steady for the whole of a transaction. They also assume that each SCL half period is several system clocks long, so that a prefetch finishes before the next falling edge. The bench changes the permission masks and the write-protect pin only between STOP and the next START. It drives the bus with a half period of eight clocks and changes SDA only while SCL is low, except for START and STOP.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BLK_W    = 3;
  localparam int PAGE_W   = 3;
  localparam int BYTE_W   = 4;
  localparam int ADDR_W   = BLK_W + PAGE_W + BYTE_W;
  localparam int INBLK_W  = PAGE_W + BYTE_W;
  localparam int CFG_W    = 5;
  localparam int NUM_BLK  = 1 << BLK_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } tws_state_e;

  typedef struct packed {
    logic rxShift;
    logic latchDev;
    logic latchWord;
    logic memWrite;
    logic incRead;
    logic txShift;
  } tws_strobe_t;
endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  tws_strobe_t       stb,
  input  logic              memRe,
  input  logic [7:0]        memRdata,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startEv,
  output logic              stopEv,
  output logic              sdaBit,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic              devRw,
  output logic              devCfg,
  output logic [BLK_W-1:0]  curBlk,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memCfg
);
  logic [2:0]        sclPipe, sdaPipe;
  logic [ADDR_W-1:0] curAddr;
  logic [CFG_W-1:0]  cfgAddr;
  logic [BLK_W-2:0]  devBlk;
  logic              rePend;
  logic [7:0]        txReg;

  // two synchroniser flops plus one history flop per line
  always_ff @(posedge clk) begin
    if (clr) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  assign sclRise = sclPipe[1] & ~sclPipe[2];
  assign sclFall = ~sclPipe[1] & sclPipe[2];
  assign startEv = sclPipe[1] & sclPipe[2] & sdaPipe[2] & ~sdaPipe[1];
  assign stopEv  = sclPipe[1] & sclPipe[2] & ~sdaPipe[2] & sdaPipe[1];
  assign sdaBit  = sdaPipe[1];

  always_ff @(posedge clk) begin
    if (clr) begin
      rxByte  <= '0;
      devRw   <= 1'b0;
      devCfg  <= 1'b0;
      devBlk  <= '0;
      curAddr <= '0;
      cfgAddr <= '0;
      rePend  <= 1'b0;
      txReg   <= '1;
    end else begin
      rePend <= memRe;
      if (stb.rxShift) rxByte <= {rxByte[6:0], sdaBit};
      if (stb.latchDev) begin
        devRw  <= rxByte[0];
        devCfg <= rxByte[4];
        devBlk <= rxByte[BLK_W-1:1];
      end
      if (stb.latchWord) begin
        if (devCfg) cfgAddr <= rxByte[CFG_W-1:0];
        else        curAddr <= {devBlk, rxByte};
      end else if (stb.memWrite && !devCfg) begin
        curAddr[BYTE_W-1:0] <= curAddr[BYTE_W-1:0] + 1'b1;   // page wrap
      end else if (stb.incRead && !devCfg) begin
        curAddr[INBLK_W-1:0] <= curAddr[INBLK_W-1:0] + 1'b1; // block wrap
      end
      if (rePend)           txReg <= memRdata;
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b1};
    end
  end

  assign txBit    = txReg[7];
  assign curBlk   = curAddr[ADDR_W-1 -: BLK_W];
  assign memAddr  = devCfg ? {{(ADDR_W-CFG_W){1'b0}}, cfgAddr} : curAddr;
  assign memWdata = rxByte;
  assign memCfg   = devCfg;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000
)(
  input  logic               clk,
  input  logic               clr,
  input  logic               wpIn,
  input  logic [NUM_BLK-1:0] permRd,
  input  logic [NUM_BLK-1:0] permWr,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startEv,
  input  logic               stopEv,
  input  logic               sdaBit,
  input  logic [7:0]         rxByte,
  input  logic               txBit,
  input  logic               devRw,
  input  logic               devCfg,
  input  logic [BLK_W-1:0]   curBlk,
  output tws_strobe_t        stb,
  output logic               memRe,
  output logic               sdaOutEn
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  tws_state_e  state, stNext;
  logic [3:0]  bitCnt, cntNext;
  logic        ackR, ackNext, wroteR, wroteNext, cfgUsed, cfgUsedNext;
  logic        fetchNext, busyStart;
  logic [BUSY_W-1:0] busyCnt;
  logic        devMainB, devCfgB, devOk, wordOk, dataOk;

  assign devMainB = rxByte[7:3] == 5'b10101;
  assign devCfgB  = rxByte[7:1] == 7'b1011100;
  assign devOk    = (devMainB || devCfgB) && (busyCnt == '0) &&
                    (!rxByte[0] || devCfgB || permRd[curBlk]);
  assign wordOk   = devCfg ? (rxByte[7:5] == 3'b000) : 1'b1;
  assign dataOk   = !wpIn && (devCfg ? !cfgUsed : permWr[curBlk]);

  always_comb begin
    stb = '0;
    stNext = state;
    cntNext = bitCnt;
    ackNext = ackR;
    wroteNext = wroteR;
    cfgUsedNext = cfgUsed;
    fetchNext = 1'b0;
    busyStart = 1'b0;
    if (startEv) begin
      stNext = ST_DEV;
      cntNext = '0;
      ackNext = 1'b0;
    end else if (stopEv) begin
      stNext = ST_IDLE;
      ackNext = 1'b0;
      busyStart = wroteR;
      wroteNext = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_WR: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            cntNext = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntNext = '0;
            if (state == ST_DEV) begin
              stb.latchDev = 1'b1;
              ackNext = devOk;
              fetchNext = devOk && rxByte[0];
              cfgUsedNext = 1'b0;
              stNext = ST_DEV_ACK;
            end else if (state == ST_WORD) begin
              stb.latchWord = wordOk;
              ackNext = wordOk;
              stNext = ST_WORD_ACK;
            end else begin
              stb.memWrite = dataOk;
              ackNext = dataOk;
              if (dataOk) begin
                wroteNext = 1'b1;
                cfgUsedNext = 1'b1;
              end
              stNext = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WORD_ACK, ST_WR_ACK: begin
          if (sclFall) begin
            if (!ackR)                  stNext = ST_SKIP;
            else if (state == ST_DEV_ACK) stNext = devRw ? ST_RD : ST_WORD;
            else                        stNext = ST_WR;
            ackNext = 1'b0;
          end
        end
        ST_RD: begin
          if (sclRise) cntNext = bitCnt + 4'd1;
          else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              stNext = ST_RD_ACK;
              cntNext = '0;
            end else stb.txShift = 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ackNext = !sdaBit && !devCfg;
            stb.incRead = !devCfg;
            fetchNext = !sdaBit && !devCfg;
          end else if (sclFall) begin
            stNext = ackR ? ST_RD : ST_SKIP;
            ackNext = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackR    <= 1'b0;
      wroteR  <= 1'b0;
      cfgUsed <= 1'b0;
      memRe   <= 1'b0;
      busyCnt <= '0;
    end else begin
      state   <= stNext;
      bitCnt  <= cntNext;
      ackR    <= ackNext;
      wroteR  <= wroteNext;
      cfgUsed <= cfgUsedNext;
      memRe   <= fetchNext;
      if (busyStart)             busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
    end
  end

  assign sdaOutEn = (ackR && (state == ST_DEV_ACK || state == ST_WORD_ACK ||
                              state == ST_WR_ACK)) ||
                    (state == ST_RD && !txBit);
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               protN,
  input  logic               wpIn,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOutEn,
  input  logic [NUM_BLK-1:0] permRd,
  input  logic [NUM_BLK-1:0] permWr,
  output logic               memCfg,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWe,
  output logic [7:0]         memWdata,
  output logic               memRe,
  input  logic [7:0]         memRdata
);
  logic             clr;
  tws_strobe_t      stb;
  logic             sclRise, sclFall, startEv, stopEv, sdaBit, txBit, devRw, devCfg;
  logic [7:0]       rxByte;
  logic [BLK_W-1:0] curBlk;

  assign clr   = !rstN || !protN;
  assign memWe = stb.memWrite;

  tws_datapath u_dp (
    .clk(clk), .clr(clr), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .memRe(memRe), .memRdata(memRdata),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .sdaBit(sdaBit), .rxByte(rxByte), .txBit(txBit), .devRw(devRw),
    .devCfg(devCfg), .curBlk(curBlk), .memAddr(memAddr),
    .memWdata(memWdata), .memCfg(memCfg)
  );

  tws_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .clr(clr), .wpIn(wpIn), .permRd(permRd), .permWr(permWr),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .sdaBit(sdaBit), .rxByte(rxByte), .txBit(txBit), .devRw(devRw),
    .devCfg(devCfg), .curBlk(curBlk), .stb(stb), .memRe(memRe),
    .sdaOutEn(sdaOutEn)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               protN,
  input logic               wpIn,
  input logic               sdaOutEn,
  input logic [NUM_BLK-1:0] permRd,
  input logic [NUM_BLK-1:0] permWr,
  input logic               memCfg,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               memWe,
  input logic               memRe
);
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memRe); // R11
  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !wpIn); // R7
  AST_PERM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memCfg) |-> permWr[memAddr[ADDR_W-1 -: BLK_W]]); // R8
  AST_PERM_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && !memCfg) |-> permRd[memAddr[ADDR_W-1 -: BLK_W]]); // R8
  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((memWe || memRe) && memCfg) |-> (memAddr < ADDR_W'(1 << CFG_W))); // R5
  AST_PROT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !protN |=> (!sdaOutEn && !memWe && !memRe)); // R10
endmodule

bind tws_eeprom_slave tws_checker u_chk (
  .clk(clk), .rstN(rstN), .protN(protN), .wpIn(wpIn), .sdaOutEn(sdaOutEn),
  .permRd(permRd), .permWr(permWr), .memCfg(memCfg), .memAddr(memAddr),
  .memWe(memWe), .memRe(memRe)
);

// File: tb/tws_eeprom_slave_tb.sv
module tws_eeprom_slave_tb;
  localparam int BUSY = 2000;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0, protN = 1'b1, wpIn = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOutEn, sdaLine;
  logic [7:0] permRd = 8'hFF, permWr = 8'hFF;
  logic memCfg, memWe, memRe;
  logic [9:0] memAddr;
  logic [7:0] memWdata, memRdata;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  logic [7:0] envMem [1024];
  logic [7:0] envCfg [32];
  logic [7:0] refMem [1024];
  logic [18:0] expQ [$];

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOutEn;

  tws_eeprom_slave #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .protN(protN), .wpIn(wpIn), .sclIn(sclM),
    .sdaIn(sdaLine), .sdaOutEn(sdaOutEn), .permRd(permRd), .permWr(permWr),
    .memCfg(memCfg), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRe(memRe), .memRdata(memRdata)
  );

  // memory behind the port
  always @(posedge clk) begin
    if (memRe) memRdata <= memCfg ? envCfg[memAddr[4:0]] : envMem[memAddr];
    if (memWe) begin
      if (memCfg) envCfg[memAddr[4:0]] <= memWdata;
      else        envMem[memAddr] <= memWdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of write strobes against the expected write stream
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) check("R7/R8 unexpected write", {13'd0, memCfg, memAddr, memWdata}, 32'hFFFFFFFF);
      else check("R3/R5 write stream", {13'd0, memCfg, memAddr, memWdata}, {13'd0, expQ.pop_front()});
    end
  end

  task automatic expectWr(bit cfg, logic [9:0] a, logic [7:0] d);
    expQ.push_back({cfg, a, d});
    if (!cfg) refMem[a] = d;
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; hw(); sclM = 1'b1; hw(); sdaM = 1'b0; hw(); sclM = 1'b0; hw();
  endtask

  task automatic stopC();
    sdaM = 1'b0; hw(); sclM = 1'b1; hw(); sdaM = 1'b1; hw();
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hw(); sclM = 1'b1; hw(); sclM = 1'b0;
    end
    sdaM = 1'b1; hw(); sclM = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = !sdaLine;
    repeat (H/2) @(negedge clk);
    sclM = 1'b0;
  endtask

  task automatic readByte(bit mAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); sclM = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sdaLine;
      repeat (H/2) @(negedge clk);
      sclM = 1'b0;
    end
    sdaM = !mAck; hw(); sclM = 1'b1; hw(); sclM = 1'b0; sdaM = 1'b1;
  endtask

  task automatic waitBusy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (BUSY * 40) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) begin
      envMem[i] = 8'(i) ^ 8'h5A;
      refMem[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 32; i++) envCfg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset sda", {31'd0, sdaOutEn}, 0);
    check("R11 reset port", {30'd0, memWe, memRe}, 0);

    // R1: foreign device codes
    startC(); sendByte(8'hA0, ack); check("R1 code A0 nack", {31'd0, ack}, 0); stopC();
    startC(); sendByte(8'h50, ack); check("R1 code 50 nack", {31'd0, ack}, 0); stopC();

    // R2/R3: page write with wrap, address 0x2B4
    startC(); sendByte(8'hAC, ack); check("R1 code AC ack", {31'd0, ack}, 1);
    sendByte(8'hB4, ack); check("R2 word ack", {31'd0, ack}, 1);
    for (int k = 0; k < 14; k++) begin
      expectWr(0, 10'h2B0 | 10'((4 + k) % 16), 8'hC0 + 8'(k));
      sendByte(8'hC0 + 8'(k), ack);
      check("R3 data ack", {31'd0, ack}, 1);
    end
    stopC(); waitBusy();

    // R4: read ignores device block bits, continues from 0x2B2
    startC(); sendByte(8'hA9, ack); check("R4 read ack", {31'd0, ack}, 1);
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, d);
      check("R4/R11 read after write", {24'd0, d}, {24'd0, refMem[10'h2B2 + 10'(k)]});
    end
    stopC();

    // R4: block wrap from 0x3FE
    startC(); sendByte(8'hAE, ack); sendByte(8'hFE, ack); stopC();
    startC(); sendByte(8'hAB, ack); check("R4 read ack", {31'd0, ack}, 1);
    readByte(1, d); check("R4 byte 3FE", {24'd0, d}, {24'd0, refMem[10'h3FE]});
    readByte(1, d); check("R4 byte 3FF", {24'd0, d}, {24'd0, refMem[10'h3FF]});
    readByte(1, d); check("R4 wrap 380", {24'd0, d}, {24'd0, refMem[10'h380]});
    readByte(0, d); check("R4 wrap 381", {24'd0, d}, {24'd0, refMem[10'h381]});
    stopC();

    // R5/R6: configuration space
    startC(); sendByte(8'hB8, ack); check("R5 cfg code ack", {31'd0, ack}, 1);
    sendByte(8'h13, ack); check("R5 cfg word ack", {31'd0, ack}, 1);
    expectWr(1, 10'h013, 8'h77);
    sendByte(8'h77, ack); check("R6 first cfg byte ack", {31'd0, ack}, 1);
    sendByte(8'h55, ack); check("R6 second cfg byte nack", {31'd0, ack}, 0);
    stopC(); waitBusy();
    startC(); sendByte(8'hB8, ack); sendByte(8'h13, ack);
    startC(); sendByte(8'hB9, ack); check("R12 repeated start ack", {31'd0, ack}, 1);
    readByte(1, d); check("R6 cfg read", {24'd0, d}, 32'h77);
    readByte(0, d); check("R6 cfg second read FF", {24'd0, d}, 32'hFF);
    stopC();
    startC(); sendByte(8'hB8, ack); sendByte(8'h25, ack);
    check("R5 cfg word out of range nack", {31'd0, ack}, 0); stopC();

    // R7: write protect
    wpIn = 1'b1;
    startC(); sendByte(8'hA8, ack); sendByte(8'h10, ack);
    check("R7 word ack under wp", {31'd0, ack}, 1);
    sendByte(8'h99, ack); check("R7 data nack under wp", {31'd0, ack}, 0);
    stopC(); wpIn = 1'b0;
    startC(); sendByte(8'hA9, ack); check("R7/R9 no busy after refused write", {31'd0, ack}, 1);
    readByte(0, d); check("R7 address latched", {24'd0, d}, {24'd0, refMem[10'h010]});
    stopC();

    // R8: permissions on block 2
    permWr = 8'hFB;
    startC(); sendByte(8'hAA, ack); sendByte(8'h05, ack);
    sendByte(8'h11, ack); check("R8 write denied", {31'd0, ack}, 0); stopC();
    permRd = 8'hFB;
    startC(); sendByte(8'hA9, ack); check("R8 read denied", {31'd0, ack}, 0); stopC();
    permRd = 8'hFF; permWr = 8'hFF;
    startC(); sendByte(8'hA9, ack); readByte(0, d);
    check("R8 block 2 unchanged", {24'd0, d}, {24'd0, refMem[10'h105]}); stopC();

    // R9: busy window
    startC(); sendByte(8'hA8, ack); sendByte(8'h20, ack);
    expectWr(0, 10'h020, 8'h3C);
    sendByte(8'h3C, ack); stopC();
    startC(); sendByte(8'hA8, ack); check("R9 busy nack", {31'd0, ack}, 0); stopC();
    waitBusy();
    startC(); sendByte(8'hA8, ack); check("R9 ready ack", {31'd0, ack}, 1);
    sendByte(8'h20, ack);
    startC(); sendByte(8'hA9, ack); readByte(0, d);
    check("R9 written value", {24'd0, d}, 32'h3C); stopC();

    // R10/R11: power-good reset during a read
    startC(); sendByte(8'hAA, ack); sendByte(8'h55, ack); stopC();
    startC(); sendByte(8'hA9, ack);
    repeat (5) @(negedge clk);
    check("R11 msb driven first", {31'd0, sdaOutEn}, 1);
    protN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 sda released", {31'd0, sdaOutEn}, 0);
    protN = 1'b1;
    stopC();
    startC(); sendByte(8'hA9, ack); readByte(0, d);
    check("R10 address cleared", {24'd0, d}, {24'd0, refMem[10'h000]}); stopC();

    repeat (10) @(negedge clk);
    check("R3 all expected writes seen", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule